// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits at the decode stage of an in-order pipeline that feeds three floating-point units of unequal length: a pipelined adder, a pipelined multiplier and an unpipelined divider. Each cycle it receives one candidate instruction: a valid bit, an operation kind, two source register numbers and a destination register number. From these it decides whether the candidate may issue in this cycle or must stall. The candidate is held at the stage inputs until `issue` is seen.

The block keeps one destination tag and one valid bit for every adder and multiplier stage, plus a countdown and a tag for the divider. It also keeps a vector that reserves the single register write port, indexed by the number of cycles until writeback. Four kinds of conflict stall the candidate: divider busy, write-port collision, read-after-write and write-after-write. No write-after-read check is made, because operands are always read in program order at decode. The arithmetic, operand forwarding, exceptions and register storage are outside this block.

Top module: `fp_issue_interlock`

## Requirements
- R1: With `inValid` low, `issue` and `stall` are both low. With `inValid` high, exactly one of `issue` and `stall` is high.
- R2: `divBusy` goes high in the cycle after a divide issues and stays high for DIV_CYCLES (default 24) cycles. A divide candidate stalls while `divBusy` is high.
- R3: Writeback latencies are ADD_DEPTH (4) cycles for an add, MUL_DEPTH (7) cycles for a multiply and DIV_CYCLES (24) cycles for a divide. A writing candidate stalls if any in-flight operation writes back in the same cycle the candidate would.
- R4: A candidate stalls if either of its source registers equals the destination of an in-flight operation that is not yet in its final cycle.
- R5: A writing candidate stalls if its destination equals the destination of any in-flight operation, including one in its final cycle.
- R6: Register 0 never causes a read-after-write or write-after-write stall, either as a source, as the candidate's destination or as a tracked destination.
- R7: `addOcc[i]` and `mulOcc[i]` are high exactly when an add or multiply occupies stage i+1. An issued operation enters stage 1 on the next cycle and advances one stage per cycle. All occupancy is clear after reset.
- R8: `inKind` encodings are 0 = add, 1 = multiply, 2 = divide, 3 = operand-only. An operand-only candidate is checked for read-after-write only. It reserves no write port, occupies no unit, and its destination is not compared.
- R9: A candidate whose destination equals a source register of an in-flight operation issues without stalling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Candidate instruction present |
| inKind | input | 2 | Operation kind (see R8) |
| srcA | input | REG_W | First source register |
| srcB | input | REG_W | Second source register |
| dst | input | REG_W | Destination register |
| issue | output | 1 | Candidate issues this cycle |
| stall | output | 1 | Candidate is held this cycle |
| addOcc | output | ADD_DEPTH | Adder stage occupancy, bit 0 = first stage |
| mulOcc | output | MUL_DEPTH | Multiplier stage occupancy, bit 0 = first stage |
| divBusy | output | 1 | Divider occupied |

## Verification
The bench sweeps every producer kind against every candidate kind, for five register relations and for gaps from 0 to 25 idle cycles. This covers the boundaries where a hazard disappears. Those boundaries are:
- a producer entering its final stage, where a read-after-write stall must lift but a write-after-write stall must not;
- a multiply issued three cycles before an add, which collides on the write port;
- a second divide arriving exactly when the divider frees up.

A design that compared against the final stage on read-after-write would hold a consumer for one extra cycle. One that shifted the write-port vector in the wrong direction would let a colliding add through. One that kept the divider busy one cycle too long would delay back-to-back divides. Register 0, operand-only candidates and write-after-read pairs are swept as well, where any stall is wrong. A pseudo-random stream with few distinct registers is also run against the bench's own timing model.

// File: rtl/fpIlkPkg.sv
`timescale 1ns/1ps
package fpIlkPkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_DIV = 2'd2,
    OP_USE = 2'd3
  } opKind_e;

  // Strobes from control to datapath: which unit accepts the candidate.
  typedef struct packed {
    logic goAdd;
    logic goMul;
    logic goDiv;
  } ilkStrobe_t;
endpackage

// File: rtl/ilkDatapath.sv
`timescale 1ns/1ps
module ilkDatapath
  import fpIlkPkg::*;
#(
  parameter int ADD_DEPTH  = 4,
  parameter int MUL_DEPTH  = 7,
  parameter int DIV_CYCLES = 24,
  parameter int REG_W      = 5,
  localparam int WB_MAX = (DIV_CYCLES > MUL_DEPTH)
                          ? ((DIV_CYCLES > ADD_DEPTH) ? DIV_CYCLES : ADD_DEPTH)
                          : ((MUL_DEPTH > ADD_DEPTH) ? MUL_DEPTH : ADD_DEPTH),
  localparam int CNT_W = $clog2(DIV_CYCLES + 1)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  ilkStrobe_t                           strobe,
  input  logic [REG_W-1:0]                     dst,
  output logic [ADD_DEPTH-1:0]                 addV,
  output logic [ADD_DEPTH-1:0][REG_W-1:0]      addTag,
  output logic [MUL_DEPTH-1:0]                 mulV,
  output logic [MUL_DEPTH-1:0][REG_W-1:0]      mulTag,
  output logic [CNT_W-1:0]                     divCnt,
  output logic [REG_W-1:0]                     divTag,
  output logic [WB_MAX-1:0]                    wbRes
);
  logic [ADD_DEPTH-1:0]            addVN;
  logic [ADD_DEPTH-1:0][REG_W-1:0] addTagN;
  logic [MUL_DEPTH-1:0]            mulVN;
  logic [MUL_DEPTH-1:0][REG_W-1:0] mulTagN;
  logic [WB_MAX-1:0]               wbResN;

  // Stage tag shift: the slot at index 0 receives the issuing instruction.
  always_comb begin
    addVN[0]   = strobe.goAdd;
    addTagN[0] = dst;
    for (int i = 1; i < ADD_DEPTH; i++) begin
      addVN[i]   = addV[i-1];
      addTagN[i] = addTag[i-1];
    end
    mulVN[0]   = strobe.goMul;
    mulTagN[0] = dst;
    for (int i = 1; i < MUL_DEPTH; i++) begin
      mulVN[i]   = mulV[i-1];
      mulTagN[i] = mulTag[i-1];
    end
  end

  // Bit j of wbRes: a writeback happens j+1 cycles from now.
  // An op of latency L issuing now is L-1 cycles away on the next cycle.
  always_comb begin
    wbResN = {1'b0, wbRes[WB_MAX-1:1]};
    for (int j = 0; j < WB_MAX; j++) begin
      if ((strobe.goAdd && ADD_DEPTH == j + 2) ||
          (strobe.goMul && MUL_DEPTH == j + 2) ||
          (strobe.goDiv && DIV_CYCLES == j + 2))
        wbResN[j] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addV   <= '0;
      addTag <= '0;
      mulV   <= '0;
      mulTag <= '0;
      divCnt <= '0;
      divTag <= '0;
      wbRes  <= '0;
    end else begin
      addV   <= addVN;
      addTag <= addTagN;
      mulV   <= mulVN;
      mulTag <= mulTagN;
      wbRes  <= wbResN;
      if (strobe.goDiv) begin
        divCnt <= CNT_W'(DIV_CYCLES);
        divTag <= dst;
      end else if (divCnt != '0) begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilkCtrl.sv
`timescale 1ns/1ps
module ilkCtrl
  import fpIlkPkg::*;
#(
  parameter int ADD_DEPTH  = 4,
  parameter int MUL_DEPTH  = 7,
  parameter int DIV_CYCLES = 24,
  parameter int REG_W      = 5,
  localparam int WB_MAX = (DIV_CYCLES > MUL_DEPTH)
                          ? ((DIV_CYCLES > ADD_DEPTH) ? DIV_CYCLES : ADD_DEPTH)
                          : ((MUL_DEPTH > ADD_DEPTH) ? MUL_DEPTH : ADD_DEPTH),
  localparam int CNT_W = $clog2(DIV_CYCLES + 1)
) (
  input  logic                                 inValid,
  input  opKind_e                              inKind,
  input  logic [REG_W-1:0]                     srcA,
  input  logic [REG_W-1:0]                     srcB,
  input  logic [REG_W-1:0]                     dst,
  input  logic [ADD_DEPTH-1:0]                 addV,
  input  logic [ADD_DEPTH-1:0][REG_W-1:0]      addTag,
  input  logic [MUL_DEPTH-1:0]                 mulV,
  input  logic [MUL_DEPTH-1:0][REG_W-1:0]      mulTag,
  input  logic [CNT_W-1:0]                     divCnt,
  input  logic [REG_W-1:0]                     divTag,
  input  logic [WB_MAX-1:0]                    wbRes,
  output logic                                 issue,
  output logic                                 stall,
  output ilkStrobe_t                           strobe
);
  logic writes, rawHit, wawHit, portHit, structHit, hazard;
  int   lat;

  function automatic logic readsTag(input logic [REG_W-1:0] tag,
                                    input logic [REG_W-1:0] a,
                                    input logic [REG_W-1:0] b);
    return (tag != '0) && ((tag == a) || (tag == b));
  endfunction

  always_comb begin
    unique case (inKind)
      OP_ADD:  lat = ADD_DEPTH;
      OP_MUL:  lat = MUL_DEPTH;
      OP_DIV:  lat = DIV_CYCLES;
      default: lat = 0;
    endcase
    writes = (inKind != OP_USE);

    // Read-after-write: every stage except the final one of each unit.
    rawHit = 1'b0;
    for (int i = 0; i < ADD_DEPTH - 1; i++)
      if (addV[i] && readsTag(addTag[i], srcA, srcB)) rawHit = 1'b1;
    for (int i = 0; i < MUL_DEPTH - 1; i++)
      if (mulV[i] && readsTag(mulTag[i], srcA, srcB)) rawHit = 1'b1;
    if (divCnt > CNT_W'(1) && readsTag(divTag, srcA, srcB)) rawHit = 1'b1;

    // Write-after-write: every occupied stage, the final one included.
    wawHit = 1'b0;
    if (writes && dst != '0) begin
      for (int i = 0; i < ADD_DEPTH; i++)
        if (addV[i] && addTag[i] == dst) wawHit = 1'b1;
      for (int i = 0; i < MUL_DEPTH; i++)
        if (mulV[i] && mulTag[i] == dst) wawHit = 1'b1;
      if (divCnt != '0 && divTag == dst) wawHit = 1'b1;
    end

    portHit = 1'b0;
    for (int k = 0; k < WB_MAX; k++)
      if (writes && k + 1 == lat) portHit = wbRes[k];

    structHit = (inKind == OP_DIV) && (divCnt != '0);
    hazard    = structHit | portHit | rawHit | wawHit;

    issue        = inValid & ~hazard;
    stall        = inValid & hazard;
    strobe.goAdd = issue && (inKind == OP_ADD);
    strobe.goMul = issue && (inKind == OP_MUL);
    strobe.goDiv = issue && (inKind == OP_DIV);
  end
endmodule

// File: rtl/fp_issue_interlock.sv
`timescale 1ns/1ps
module fp_issue_interlock
  import fpIlkPkg::*;
#(
  parameter int ADD_DEPTH  = 4,
  parameter int MUL_DEPTH  = 7,
  parameter int DIV_CYCLES = 24,
  parameter int REG_W      = 5,
  localparam int WB_MAX = (DIV_CYCLES > MUL_DEPTH)
                          ? ((DIV_CYCLES > ADD_DEPTH) ? DIV_CYCLES : ADD_DEPTH)
                          : ((MUL_DEPTH > ADD_DEPTH) ? MUL_DEPTH : ADD_DEPTH),
  localparam int CNT_W = $clog2(DIV_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           inKind,
  input  logic [REG_W-1:0]     srcA,
  input  logic [REG_W-1:0]     srcB,
  input  logic [REG_W-1:0]     dst,
  output logic                 issue,
  output logic                 stall,
  output logic [ADD_DEPTH-1:0] addOcc,
  output logic [MUL_DEPTH-1:0] mulOcc,
  output logic                 divBusy
);
  ilkStrobe_t                      strobe;
  logic [ADD_DEPTH-1:0]            addV;
  logic [ADD_DEPTH-1:0][REG_W-1:0] addTag;
  logic [MUL_DEPTH-1:0]            mulV;
  logic [MUL_DEPTH-1:0][REG_W-1:0] mulTag;
  logic [CNT_W-1:0]                divCnt;
  logic [REG_W-1:0]                divTag;
  logic [WB_MAX-1:0]               wbRes;

  ilkCtrl #(
    .ADD_DEPTH(ADD_DEPTH), .MUL_DEPTH(MUL_DEPTH),
    .DIV_CYCLES(DIV_CYCLES), .REG_W(REG_W)
  ) ctrl (
    .inValid(inValid), .inKind(opKind_e'(inKind)),
    .srcA(srcA), .srcB(srcB), .dst(dst),
    .addV(addV), .addTag(addTag), .mulV(mulV), .mulTag(mulTag),
    .divCnt(divCnt), .divTag(divTag), .wbRes(wbRes),
    .issue(issue), .stall(stall), .strobe(strobe)
  );

  ilkDatapath #(
    .ADD_DEPTH(ADD_DEPTH), .MUL_DEPTH(MUL_DEPTH),
    .DIV_CYCLES(DIV_CYCLES), .REG_W(REG_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dst(dst),
    .addV(addV), .addTag(addTag), .mulV(mulV), .mulTag(mulTag),
    .divCnt(divCnt), .divTag(divTag), .wbRes(wbRes)
  );

  assign addOcc  = addV;
  assign mulOcc  = mulV;
  assign divBusy = (divCnt != '0);
endmodule

// File: rtl/fpIlkChecker.sv
`timescale 1ns/1ps
module fpIlkChecker #(
  parameter int ADD_DEPTH = 4,
  parameter int MUL_DEPTH = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [1:0]           inKind,
  input logic                 issue,
  input logic                 stall,
  input logic [ADD_DEPTH-1:0] addOcc,
  input logic [MUL_DEPTH-1:0] mulOcc,
  input logic                 divBusy
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!issue && !stall));

  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (issue ^ stall));

  assert_div_busy_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inKind == 2'd2 && divBusy) |-> stall);

  assert_div_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issue && inKind == 2'd2) |=> divBusy);

  assert_add_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issue && inKind == 2'd0) |=> addOcc[0]);

  assert_use_untracked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issue && inKind == 2'd3) |=> (!addOcc[0] && !mulOcc[0]));

  if (MUL_DEPTH >= 2) begin : g_mulShift
    assert_mul_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
      mulOcc[0] |=> mulOcc[1]);
  end

  // A multiply in stage MUL_DEPTH-ADD_DEPTH writes back together with an add issued now.
  if (MUL_DEPTH > ADD_DEPTH) begin : g_portClash
    assert_port_clash_R3: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inKind == 2'd0 && mulOcc[MUL_DEPTH-ADD_DEPTH-1]) |-> stall);
  end
endmodule

bind fp_issue_interlock fpIlkChecker #(
  .ADD_DEPTH(ADD_DEPTH), .MUL_DEPTH(MUL_DEPTH)
) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inKind(inKind),
  .issue(issue), .stall(stall), .addOcc(addOcc), .mulOcc(mulOcc),
  .divBusy(divBusy)
);

// File: tb/fp_issue_interlock_test.sv
`timescale 1ns/1ps
module fp_issue_interlock_test;
  localparam int AD = 4, MD = 7, DC = 24, RW = 5, NREC = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inKind = '0;
  logic [RW-1:0] srcA = '0, srcB = '0, dst = '0;
  logic issue, stall, divBusy;
  logic [AD-1:0] addOcc;
  logic [MD-1:0] mulOcc;

  always #5 clk = ~clk;

  fp_issue_interlock #(.ADD_DEPTH(AD), .MUL_DEPTH(MD), .DIV_CYCLES(DC), .REG_W(RW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKind(inKind),
    .srcA(srcA), .srcB(srcB), .dst(dst), .issue(issue), .stall(stall),
    .addOcc(addOcc), .mulOcc(mulOcc), .divBusy(divBusy)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 1'b0;
  // Reference timing model: issue cycle, latency, destination, kind of each issued op.
  int opT[NREC], opL[NREC], opD[NREC], opK[NREC];
  int head = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int latOf(input int k);
    return (k == 0) ? AD : (k == 1) ? MD : (k == 2) ? DC : 0;
  endfunction

  function automatic bit anyInFlight();
    for (int e = 0; e < NREC; e++)
      if (cyc - opT[e] >= 1 && cyc - opT[e] <= opL[e]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // One cycle: drive candidate, compare outputs to the model, record expected issue.
  task automatic stepCycle(input bit v, input int k, input int a, input int b, input int d,
                           input string tag, output bit issued);
    bit dBusy, port, raw, waw, hz, expIssue;
    int lat, s, expAdd, expMul;
    string why;
    @(negedge clk);
    inValid = v; inKind = 2'(k); srcA = RW'(a); srcB = RW'(b); dst = RW'(d);
    #1;
    lat = latOf(k);
    dBusy = 0; port = 0; raw = 0; waw = 0; expAdd = 0; expMul = 0;
    for (int e = 0; e < NREC; e++) begin
      s = cyc - opT[e];
      if (s >= 1 && s <= opL[e]) begin
        if (opK[e] == 2) dBusy = 1;
        if (opK[e] == 0) expAdd |= (1 << (s - 1));
        if (opK[e] == 1) expMul |= (1 << (s - 1));
        if (s <= opL[e] - 1 && opD[e] != 0 && (opD[e] == a || opD[e] == b)) raw = 1;
        if (k != 3 && d != 0 && opD[e] == d) waw = 1;
        if (k != 3 && opT[e] + opL[e] == cyc + lat) port = 1;
      end
    end
    hz = (k == 2 && dBusy) || port || raw || waw;
    expIssue = v && !hz;
    if (tag != "") why = tag;
    else if (!v) why = "R1";
    else if (k == 2 && dBusy) why = "R2";
    else if (port) why = "R3";
    else if (raw) why = "R4";
    else if (waw) why = "R5";
    else why = "R1";
    check(issue == expIssue, why, "issue", int'(issue), int'(expIssue));
    check(stall == (v && hz), why, "stall", int'(stall), int'(v && hz));
    check(int'(addOcc) == expAdd, "R7", "addOcc", int'(addOcc), expAdd);
    check(int'(mulOcc) == expMul, "R7", "mulOcc", int'(mulOcc), expMul);
    check(divBusy == dBusy, "R2", "divBusy", int'(divBusy), int'(dBusy));
    if (expIssue && k != 3) begin
      opT[head] = cyc; opL[head] = lat; opD[head] = d; opK[head] = k;
      head = (head + 1) % NREC;
    end
    issued = expIssue;
  endtask

  task automatic presentUntilIssued(input int k, input int a, input int b, input int d,
                                    input string tag);
    bit got = 0;
    for (int n = 0; n < 40 && !got; n++) stepCycle(1, k, a, b, d, tag, got);
  endtask

  initial begin
    bit dummy;
    for (int e = 0; e < NREC; e++) begin opT[e] = -1000; opL[e] = 0; opD[e] = 0; opK[e] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // Reset state: nothing tracked, idle candidate gives no outcome (R7, R1).
    #1;
    check(addOcc == '0 && mulOcc == '0 && !divBusy, "R7", "reset occupancy",
          int'({addOcc, mulOcc, divBusy}), 0);
    stepCycle(0, 0, 1, 2, 3, "R1", dummy);

    // Sweep: producer kind x candidate kind x register relation x gap.
    for (int c1 = 0; c1 < 3; c1++)
      for (int c2 = 0; c2 < 4; c2++)
        for (int rel = 0; rel < 5; rel++)
          for (int gap = 0; gap < 26; gap++) begin
            int a2, b2, d2, d1;
            string tag;
            while (anyInFlight()) stepCycle(0, 0, 0, 0, 0, "", dummy);
            d1 = (rel == 4) ? 0 : 12;
            case (rel)
              0: begin a2 = 13; b2 = 14; d2 = 15; end
              1: begin a2 = 12; b2 = 14; d2 = 15; end
              2: begin a2 = 13; b2 = 14; d2 = 12; end
              3: begin a2 = 13; b2 = 14; d2 = 10; end
              default: begin a2 = 0; b2 = 0; d2 = 0; end
            endcase
            tag = (rel == 3) ? "R9" : (rel == 4) ? "R6" : (c2 == 3) ? "R8" : "";
            presentUntilIssued(c1, 10, 11, d1, "");
            for (int g = 0; g < gap; g++) stepCycle(0, 0, 0, 0, 0, "", dummy);
            presentUntilIssued(c2, a2, b2, d2, tag);
          end

    // Pseudo-random stream over four registers; stalled candidates are held.
    begin
      logic [15:0] lf = 16'hACE1;
      bit v = 0, got = 1;
      int k = 0, a = 0, b = 0, d = 0;
      for (int n = 0; n < 4000; n++) begin
        if (got || !v) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          v = lf[0] | lf[1];
          k = int'(lf[3:2]);
          a = int'(lf[5:4]); b = int'(lf[7:6]); d = int'(lf[9:8]);
        end
        stepCycle(v, k, a, b, d, "", got);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule